// File: doc/BRIEF.md
# Banked Binary Point Register Unit

This block holds the binary point settings of an interrupt controller's per-CPU interface. Each CPU owns a primary binary point register and, when the security extension is built in, a separate banked copy that Non-Secure software sees. Register accesses arrive as single-cycle strobes. Each strobe carries a CPU index, a word offset, a write flag, a security attribute and write data. Every strobe is answered on the next cycle with a response strobe and read data.

A per-CPU share control comes from the CPU control register, which lives outside this block. When the share bit is set, Non-Secure software does not see its banked copy. Its reads return the primary value plus one, saturated at 7, and its writes are dropped, although the access still completes. Written values keep only their low three bits and are raised to a floor that belongs to each register. Both binary points of every CPU are driven continuously to the priority-grouping logic. The Non-Secure output applies the share rule, so preemption logic sees the same value a Non-Secure read would return.

Top module: `bpr_bank_unit`

## Requirements
- R1: After reset every primary register holds PRI_MIN (default 0) and every banked copy holds PRI_MIN+1. rd_valid_o is 0 after reset.
- R2: Every cycle with acc_valid_i high is answered one cycle later with rd_valid_o high, and only those cycles are answered. The rd_data_o of a write response is 0.
- R3: A Secure access (acc_secure_i=1) at word offset 0x08 reads or writes the primary register of the addressed CPU. It has no effect on any other CPU.
- R4: A Non-Secure access at offset 0x08 with that CPU's share bit at 0 reads or writes the banked copy. The primary register is left unchanged.
- R5: A Non-Secure read at offset 0x08 with the share bit at 1 returns the primary value plus one, saturated at 7.
- R6: A Non-Secure write at offset 0x08 with the share bit at 1 changes no register. It is still answered with rd_valid_o.
- R7: A write keeps bits [2:0] of acc_wdata_i. The result is then raised to PRI_MIN for the primary register, or to PRI_MIN+1 for the banked copy.
- R8: An access at any offset other than 0x08 reads as 0 and writes nothing.
- R9: bp_sec_o[3c+:3] shows the primary value of CPU c. bp_ns_o[3c+:3] shows the value that a Non-Secure read of CPU c would return.
- R10: An access whose CPU index is NUM_CPU or more reads as 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access strobe |
| acc_write_i | input | 1 | 1 for a write, 0 for a read |
| acc_secure_i | input | 1 | Security attribute of the access, 1 = Secure |
| acc_cpu_i | input | CPU_W | CPU index of the access |
| acc_offset_i | input | OFS_W | Word offset within the CPU interface |
| acc_wdata_i | input | DATA_W | Write data |
| share_bp_i | input | NUM_CPU | Per-CPU share control bit |
| rd_valid_o | output | 1 | Response strobe, one cycle after the access |
| rd_data_o | output | 3 | Read data of the response |
| bp_sec_o | output | 3*NUM_CPU | Primary binary point per CPU |
| bp_ns_o | output | 3*NUM_CPU | Effective Non-Secure binary point per CPU |

## Verification
The bound checker watches the following on every cycle:
- the one-cycle response timing and the zero data of write responses;
- zero read data for a wrong offset or a CPU index out of range, and the fact that such accesses leave the primary values alone;
- the floor of the Non-Secure output;
- the primary value holding still across a shared Non-Secure write.

The directed scenarios cover the rest:
- which register each combination of security attribute and share bit selects;
- the saturation at 7;
- masking and clamping of written data;
- isolation between CPUs;
- the banked value surviving while sharing is on and reappearing when it is turned off.

// File: rtl/bpr_bank_pkg.sv
package bpr_bank_pkg;
   localparam int unsigned BP_W = 3;
   typedef logic [BP_W-1:0] bp_t;
   localparam bp_t BP_TOP = '1;

   // increment with saturation at the largest binary point
   function automatic bp_t bp_sat_inc(input bp_t v);
      return (v == BP_TOP) ? BP_TOP : v + bp_t'(1);
   endfunction
endpackage

// File: rtl/bp_clamp.sv
module bp_clamp
   import bpr_bank_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned MIN_VAL = 0
) (
   input  logic [DATA_W-1:0] raw_i,
   output bp_t               val_o
);
   logic [DATA_W-1:0] unused_hi;
   bp_t               masked;

   assign masked    = raw_i[BP_W-1:0];
   assign unused_hi = raw_i;

   generate
      if (MIN_VAL == 0) begin : g_no_floor
         assign val_o = masked;
      end else begin : g_floor
         localparam bp_t FLOOR = bp_t'(MIN_VAL);
         assign val_o = (masked < FLOOR) ? FLOOR : masked;
      end
   endgenerate
endmodule

// File: rtl/bp_ns_view.sv
module bp_ns_view
   import bpr_bank_pkg::*;
#(
   parameter bit HAS_SEC = 1'b1
) (
   input  logic share_i,
   input  bp_t  pri_i,
   input  bp_t  ali_i,
   output bp_t  view_o
);
   generate
      if (HAS_SEC) begin : g_banked
         assign view_o = share_i ? bp_sat_inc(pri_i) : ali_i;
      end else begin : g_flat
         logic unused_view;
         assign unused_view = share_i ^ (^ali_i);
         assign view_o      = pri_i;
      end
   endgenerate
endmodule

// File: rtl/bp_cpu_slice.sv
module bp_cpu_slice
   import bpr_bank_pkg::*;
#(
   parameter bit          HAS_SEC = 1'b1,
   parameter int unsigned PRI_MIN = 0,
   parameter int unsigned DATA_W  = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_pri_i,
   input  logic              wr_ali_i,
   input  logic              share_i,
   input  logic [DATA_W-1:0] wdata_i,
   output bp_t               pri_o,
   output bp_t               ns_view_o
);
   localparam int unsigned ALI_MIN = PRI_MIN + 1;

   bp_t pri_q, pri_next, ali_q;

   bp_clamp #(.DATA_W(DATA_W), .MIN_VAL(PRI_MIN)) i_pri_clamp (
      .raw_i (wdata_i),
      .val_o (pri_next)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pri_q <= bp_t'(PRI_MIN);
      else if (wr_pri_i) pri_q <= pri_next;
   end

   generate
      if (HAS_SEC) begin : g_alias
         bp_t ali_next;
         bp_clamp #(.DATA_W(DATA_W), .MIN_VAL(ALI_MIN)) i_ali_clamp (
            .raw_i (wdata_i),
            .val_o (ali_next)
         );
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)       ali_q <= bp_t'(ALI_MIN);
            else if (wr_ali_i) ali_q <= ali_next;
         end
      end else begin : g_no_alias
         logic unused_wr;
         assign unused_wr = wr_ali_i;
         assign ali_q     = bp_t'(ALI_MIN);
      end
   endgenerate

   bp_ns_view #(.HAS_SEC(HAS_SEC)) i_view (
      .share_i (share_i),
      .pri_i   (pri_q),
      .ali_i   (ali_q),
      .view_o  (ns_view_o)
   );

   assign pri_o = pri_q;
endmodule

// File: rtl/bpr_bank_unit.sv
module bpr_bank_unit
   import bpr_bank_pkg::*;
#(
   parameter int unsigned NUM_CPU   = 3,
   parameter bit          HAS_SEC   = 1'b1,
   parameter int unsigned PRI_MIN   = 0,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned OFS_W     = 8,
   parameter int unsigned BP_OFFSET = 8,
   localparam int unsigned CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    acc_valid_i,
   input  logic                    acc_write_i,
   input  logic                    acc_secure_i,
   input  logic [CPU_W-1:0]        acc_cpu_i,
   input  logic [OFS_W-1:0]        acc_offset_i,
   input  logic [DATA_W-1:0]       acc_wdata_i,
   input  logic [NUM_CPU-1:0]      share_bp_i,
   output logic                    rd_valid_o,
   output logic [BP_W-1:0]         rd_data_o,
   output logic [BP_W*NUM_CPU-1:0] bp_sec_o,
   output logic [BP_W*NUM_CPU-1:0] bp_ns_o
);
   initial begin
      assert (NUM_CPU >= 1) else $error("NUM_CPU must be at least 1");
      assert (PRI_MIN <= 6) else $error("PRI_MIN must leave room for the banked floor");
      assert (DATA_W >= BP_W) else $error("DATA_W too narrow");
      assert (BP_OFFSET < (1 << OFS_W)) else $error("BP_OFFSET does not fit OFS_W");
   end

   logic bp_hit, ns_path;
   bp_t  pri_val [NUM_CPU];
   bp_t  ns_val  [NUM_CPU];
   logic [NUM_CPU-1:0] cpu_sel;
   bp_t  sel_val;

   assign bp_hit  = acc_valid_i && (acc_offset_i == OFS_W'(BP_OFFSET));
   assign ns_path = HAS_SEC && !acc_secure_i;

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic wr_pri, wr_ali;
      assign cpu_sel[c] = (acc_cpu_i == CPU_W'(c));
      assign wr_pri     = bp_hit && acc_write_i && cpu_sel[c] && !ns_path;
      assign wr_ali     = bp_hit && acc_write_i && cpu_sel[c] && ns_path && !share_bp_i[c];

      bp_cpu_slice #(.HAS_SEC(HAS_SEC), .PRI_MIN(PRI_MIN), .DATA_W(DATA_W)) i_slice (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .wr_pri_i  (wr_pri),
         .wr_ali_i  (wr_ali),
         .share_i   (share_bp_i[c]),
         .wdata_i   (acc_wdata_i),
         .pri_o     (pri_val[c]),
         .ns_view_o (ns_val[c])
      );

      assign bp_sec_o[c*BP_W +: BP_W] = pri_val[c];
      assign bp_ns_o[c*BP_W +: BP_W]  = ns_val[c];
   end

   // read mux: an index with no matching CPU leaves the value at zero
   always_comb begin
      sel_val = '0;
      for (int c = 0; c < NUM_CPU; c++) begin
         if (cpu_sel[c]) sel_val = ns_path ? ns_val[c] : pri_val[c];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= acc_valid_i;
         rd_data_o  <= (bp_hit && !acc_write_i) ? sel_val : '0;
      end
   end
endmodule

// File: rtl/bpr_bank_chk.sv
module bpr_bank_chk #(
   parameter int unsigned NUM_CPU   = 3,
   parameter bit          HAS_SEC   = 1'b1,
   parameter int unsigned PRI_MIN   = 0,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned OFS_W     = 8,
   parameter int unsigned BP_OFFSET = 8,
   parameter int unsigned CPU_W     = 2
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 acc_valid_i,
   input logic                 acc_write_i,
   input logic                 acc_secure_i,
   input logic [CPU_W-1:0]     acc_cpu_i,
   input logic [OFS_W-1:0]     acc_offset_i,
   input logic [DATA_W-1:0]    acc_wdata_i,
   input logic [NUM_CPU-1:0]   share_bp_i,
   input logic                 rd_valid_o,
   input logic [2:0]           rd_data_o,
   input logic [3*NUM_CPU-1:0] bp_sec_o,
   input logic [3*NUM_CPU-1:0] bp_ns_o
);
   logic [DATA_W-1:0] unused_wd;
   assign unused_wd = acc_wdata_i;

   p_resp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_valid_i |=> rd_valid_o);
   p_no_resp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !acc_valid_i |=> !rd_valid_o);
   p_wr_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && acc_write_i) |=> (rd_data_o == 3'd0));
   p_ofs_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && acc_offset_i != OFS_W'(BP_OFFSET)) |=> (rd_data_o == 3'd0 && $stable(bp_sec_o)));
   p_cpu_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && int'(acc_cpu_i) >= NUM_CPU) |=> (rd_data_o == 3'd0 && $stable(bp_sec_o)));

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      if (HAS_SEC) begin : g_sec
         p_ns_floor_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            bp_ns_o[c*3 +: 3] >= 3'(PRI_MIN + 1));
         p_shared_wr_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (acc_valid_i && acc_write_i && !acc_secure_i && share_bp_i[c] &&
             acc_offset_i == OFS_W'(BP_OFFSET) && acc_cpu_i == CPU_W'(c))
            |=> ($stable(bp_sec_o[c*3 +: 3]) && (!share_bp_i[c] || $stable(bp_ns_o[c*3 +: 3]))));
      end
   end
endmodule

bind bpr_bank_unit bpr_bank_chk #(
   .NUM_CPU(NUM_CPU), .HAS_SEC(HAS_SEC), .PRI_MIN(PRI_MIN), .DATA_W(DATA_W),
   .OFS_W(OFS_W), .BP_OFFSET(BP_OFFSET), .CPU_W(CPU_W)
) i_bpr_bank_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
   .acc_secure_i(acc_secure_i), .acc_cpu_i(acc_cpu_i), .acc_offset_i(acc_offset_i),
   .acc_wdata_i(acc_wdata_i), .share_bp_i(share_bp_i), .rd_valid_o(rd_valid_o),
   .rd_data_o(rd_data_o), .bp_sec_o(bp_sec_o), .bp_ns_o(bp_ns_o)
);

// File: tb/test_bpr_bank_unit.sv
`timescale 1ns/1ps
module test_bpr_bank_unit;
   localparam int NCPU = 3;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        acc_valid_i = 1'b0, acc_write_i = 1'b0, acc_secure_i = 1'b0;
   logic [1:0]  acc_cpu_i = '0;
   logic [7:0]  acc_offset_i = '0;
   logic [31:0] acc_wdata_i = '0;
   logic [NCPU-1:0] share_bp_i = '0;
   logic        rd_valid_o;
   logic [2:0]  rd_data_o;
   logic [3*NCPU-1:0] bp_sec_o, bp_ns_o;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #10 clk_i = ~clk_i;

   bpr_bank_unit i_bpr_bank_unit (
      .clk_i(clk_i), .rst_ni(rst_ni), .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
      .acc_secure_i(acc_secure_i), .acc_cpu_i(acc_cpu_i), .acc_offset_i(acc_offset_i),
      .acc_wdata_i(acc_wdata_i), .share_bp_i(share_bp_i), .rd_valid_o(rd_valid_o),
      .rd_data_o(rd_data_o), .bp_sec_o(bp_sec_o), .bp_ns_o(bp_ns_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one access: drive on a falling edge, read the response one falling edge later
   task automatic acc(input int cpu, input bit wr, input bit sec, input int ofs,
                      input logic [31:0] wd, output int rd, output int vld);
      @(negedge clk_i);
      acc_valid_i = 1'b1; acc_write_i = wr; acc_secure_i = sec;
      acc_cpu_i = 2'(cpu); acc_offset_i = 8'(ofs); acc_wdata_i = wd;
      @(negedge clk_i);
      acc_valid_i = 1'b0;
      rd = int'(rd_data_o); vld = int'(rd_valid_o);
   endtask

   function automatic int sec_of(int c); return int'(bp_sec_o[c*3 +: 3]); endfunction
   function automatic int ns_of(int c);  return int'(bp_ns_o[c*3 +: 3]);  endfunction

   task automatic t_reset();
      for (int c = 0; c < NCPU; c++) begin
         chk("R1 primary reset", sec_of(c), 0);
         chk("R1 banked reset", ns_of(c), 1);
      end
      chk("R1 no response after reset", int'(rd_valid_o), 0);
   endtask

   task automatic t_secure();
      int rd, v;
      acc(0, 1, 1, 8, 32'h5, rd, v);
      chk("R2 write answered", v, 1);
      chk("R2 write data zero", rd, 0);
      acc(0, 0, 1, 8, 0, rd, v);
      chk("R3 secure read", rd, 5);
      chk("R9 secure output", sec_of(0), 5);
      acc(1, 0, 1, 8, 0, rd, v);
      chk("R3 other cpu untouched", rd, 0);
      acc(2, 1, 1, 8, 32'hF0, rd, v);
      chk("R7 primary masked", sec_of(2), 0);
   endtask

   task automatic t_banked();
      int rd, v;
      acc(0, 1, 0, 8, 32'h0, rd, v);
      chk("R7 banked floor", ns_of(0), 1);
      acc(0, 1, 0, 8, 32'h1E, rd, v);
      acc(0, 0, 0, 8, 0, rd, v);
      chk("R4 banked read masked", rd, 6);
      chk("R9 ns output banked", ns_of(0), 6);
      acc(0, 0, 1, 8, 0, rd, v);
      chk("R4 primary unchanged", rd, 5);
   endtask

   task automatic t_shared();
      int rd, v;
      @(negedge clk_i); share_bp_i[0] = 1'b1;
      acc(0, 0, 0, 8, 0, rd, v);
      chk("R5 shared read", rd, 6);
      chk("R9 ns output shared", ns_of(0), 6);
      acc(0, 1, 0, 8, 32'h2, rd, v);
      chk("R6 dropped write answered", v, 1);
      chk("R6 primary kept", sec_of(0), 5);
      @(negedge clk_i); share_bp_i[0] = 1'b0;
      @(negedge clk_i);
      chk("R6 banked kept", ns_of(0), 6);
      acc(0, 1, 1, 8, 32'h7, rd, v);
      @(negedge clk_i); share_bp_i[0] = 1'b1;
      acc(0, 0, 0, 8, 0, rd, v);
      chk("R5 saturation", rd, 7);
      acc(0, 1, 1, 8, 32'h0, rd, v);
      acc(0, 0, 0, 8, 0, rd, v);
      chk("R5 zero plus one", rd, 1);
      @(negedge clk_i); share_bp_i[0] = 1'b0;
   endtask

   task automatic t_offset();
      int rd, v;
      acc(1, 1, 1, 8, 32'h3, rd, v);
      acc(1, 0, 1, 12, 0, rd, v);
      chk("R8 other offset answered", v, 1);
      chk("R8 other offset reads zero", rd, 0);
      acc(1, 1, 1, 4, 32'h6, rd, v);
      chk("R8 other offset no write", sec_of(1), 3);
      acc(1, 1, 0, 0, 32'h6, rd, v);
      chk("R8 ns other offset no write", ns_of(1), 1);
   endtask

   task automatic t_range();
      int rd, v;
      acc(3, 1, 1, 8, 32'h4, rd, v);
      for (int c = 0; c < NCPU; c++) chk("R10 no write out of range", sec_of(c), (c == 1) ? 3 : 0);
      acc(3, 0, 1, 8, 0, rd, v);
      chk("R10 out of range reads zero", rd, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      t_reset();
      rst_ni = 1'b1;
      t_secure();
      t_banked();
      t_shared();
      t_offset();
      t_range();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk_i);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule